// File: doc/BRIEF.md
# Burst Column Address Generator

This block sits behind the command decoder of a synchronous DRAM model or controller and turns one read or write command into a stream of column addresses, one per clock. A start pulse captures a 9-bit starting column together with the burst settings in force: a length selector, an ordering selector (linear or XOR-interleaved) and a write-single flag. From the next cycle on, the block presents a column address with a valid flag on every clock until the burst is complete.

Short bursts stay inside an aligned block whose size is the burst length, so only the low column bits move. A page-length burst walks the whole 512-column row, wraps from the top column back to zero, and continues until a stop request arrives. A last-beat flag marks the final address of every burst of fixed length. A new command that arrives while a burst is running cuts that burst short, and the new burst begins on the next cycle.

Top module: `brst_col_gen`

## Requirements
- R1: While reset is high and after it, with no command, `valid_o` and `last_o` are low and `col_o` reads zero. Reset is synchronous and active high.
- R2: A command sampled with `start_i` high at a clock edge makes `valid_o` high from that edge, with `col_o` equal to the captured start column. Each later edge of the burst presents the next address.
- R3: `len_sel_i` encodes the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 4 gives a page burst. The codes 5, 6 and 7 give a single beat.
- R4: In a burst of 2, 4 or 8 beats, the column bits above bit 0, bit 1 or bit 2 respectively keep the value of the start column for every beat.
- R5: With `ilv_i` low, beat k of a burst of length L carries the low bits (start + k) mod L. For example, a 4-beat burst starting at offset 1 gives 1, 2, 3, 0.
- R6: With `ilv_i` high, beat k carries the low bits start XOR k. For example, an 8-beat burst starting at offset 5 gives 5, 4, 7, 6, 1, 0, 3, 2.
- R7: A page burst ignores `ilv_i` and counts up by one per beat across all 9 bits. It wraps from 511 to 0, never raises `last_o`, and runs until it is stopped or replaced.
- R8: `last_o` is high exactly on the final beat of a burst of fixed length, and `valid_o` is low on the following cycle unless a new command starts there.
- R9: `stop_i` sampled high during a beat, with no new command, makes that beat the last one, and `valid_o` is low from the next edge. `stop_i` has no effect while idle.
- R10: With `wr_single_i` high, a write command (`is_wr_i` high) produces exactly one beat, whatever the length selector. A read command still uses the selected length.
- R11: A command that starts during a running burst ends that burst. The new start column appears at the next edge, and a start overrides a stop sampled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Command pulse that begins a burst |
| is_wr_i | input | 1 | Command is a write (1) or a read (0) |
| col_i | input | 9 | Starting column of the burst |
| len_sel_i | input | 3 | Burst length selector |
| ilv_i | input | 1 | Interleaved ordering when high |
| wr_single_i | input | 1 | Forces writes to a single beat |
| stop_i | input | 1 | Terminates the running burst |
| col_o | output | 9 | Current column address |
| valid_o | output | 1 | A column address is presented |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
On every cycle, the assertions check the timing relations: the start column appears right after a command, the upper block bits hold steady in short bursts, bit 0 flips on every continuing beat, the burst ends after a last beat or a stop, and a page burst never flags a last beat. The exact beat orders are only shown by the bench's reference model across its scenarios. These cover linear and interleaved walks from every kind of offset, page wrap at 511, reserved length codes, the write-single rule, and truncation by new commands. The reference model compares the addresses on every clock.

// File: rtl/brst_pkg.sv
package brst_pkg;

    localparam int COL_W  = 9;
    localparam int MAX_LG = 3;

    typedef enum logic [2:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd4
    } len_sel_e;

    typedef struct packed {
        logic [1:0] lg;
        logic       ilv;
        logic       page;
    } burst_cfg_t;

    function automatic burst_cfg_t decode_len(input logic [2:0] sel);
        burst_cfg_t c;
        c = '0;
        case (sel)
            LEN_2:    c.lg = 2'd1;
            LEN_4:    c.lg = 2'd2;
            LEN_8:    c.lg = 2'd3;
            LEN_PAGE: c.page = 1'b1;
            default:  c.lg = 2'd0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/brst_cfg_dec.sv
module brst_cfg_dec
    import brst_pkg::*;
(
    input  logic [2:0]  len_sel_i,
    input  logic        ilv_i,
    input  logic        is_wr_i,
    input  logic        wr_single_i,
    output burst_cfg_t  cfg_o
);
    burst_cfg_t base_cfg;

    always_comb begin
        base_cfg = decode_len(len_sel_i);
        if (is_wr_i && wr_single_i) begin
            base_cfg.lg   = 2'd0;
            base_cfg.page = 1'b0;
        end
        base_cfg.ilv = ilv_i & ~base_cfg.page;
        cfg_o = base_cfg;
    end
endmodule

// File: rtl/brst_seq.sv
module brst_seq
    import brst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic [W-1:0] col_i,
    input  burst_cfg_t   cfg_i,
    output logic         active_o,
    output logic         last_o,
    output logic [W-1:0] base_o,
    output logic [W-1:0] beat_o,
    output burst_cfg_t   cfg_o
);
    localparam logic [W-1:0] ONE = W'(1);

    logic         active_q;
    logic [W-1:0] base_q;
    logic [W-1:0] beat_q;
    burst_cfg_t   cfg_q;
    logic [W-1:0] blk_mask;
    logic         at_end;

    always_comb begin
        blk_mask = cfg_q.page ? '1 : ((ONE << cfg_q.lg) - ONE);
        at_end   = !cfg_q.page && (beat_q == blk_mask);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            base_q   <= '0;
            beat_q   <= '0;
            cfg_q    <= '0;
        end else if (start_i) begin
            active_q <= 1'b1;
            base_q   <= col_i;
            beat_q   <= '0;
            cfg_q    <= cfg_i;
        end else if (active_q) begin
            if (stop_i || at_end) begin
                active_q <= 1'b0;
            end else begin
                beat_q <= beat_q + ONE;
            end
        end
    end

    assign active_o = active_q;
    assign last_o   = active_q & at_end;
    assign base_o   = base_q;
    assign beat_o   = beat_q;
    assign cfg_o    = cfg_q;
endmodule

// File: rtl/brst_col_map.sv
module brst_col_map
    import brst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic [W-1:0] base_i,
    input  logic [W-1:0] beat_i,
    input  burst_cfg_t   cfg_i,
    output logic [W-1:0] col_o
);
    logic [W-1:0] lin_sum;

    assign lin_sum = base_i + beat_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i < MAX_LG) begin : g_low
            logic moves;
            assign moves = cfg_i.page || (int'(cfg_i.lg) > i);
            assign col_o[i] = !moves     ? base_i[i] :
                              cfg_i.ilv  ? (base_i[i] ^ beat_i[i]) :
                                           lin_sum[i];
        end else begin : g_high
            assign col_o[i] = cfg_i.page ? lin_sum[i] : base_i[i];
        end
    end
endmodule

// File: rtl/brst_col_gen.sv
module brst_col_gen
    import brst_pkg::*;
#(
    parameter int W = COL_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic         is_wr_i,
    input  logic [W-1:0] col_i,
    input  logic [2:0]   len_sel_i,
    input  logic         ilv_i,
    input  logic         wr_single_i,
    input  logic         stop_i,
    output logic [W-1:0] col_o,
    output logic         valid_o,
    output logic         last_o
);
    burst_cfg_t   cmd_cfg;
    burst_cfg_t   run_cfg;
    logic         active;
    logic         last_beat;
    logic [W-1:0] base;
    logic [W-1:0] beat;
    logic [W-1:0] mapped;
    logic         page_q;

    brst_cfg_dec u_dec (
        .len_sel_i   (len_sel_i),
        .ilv_i       (ilv_i),
        .is_wr_i     (is_wr_i),
        .wr_single_i (wr_single_i),
        .cfg_o       (cmd_cfg)
    );

    brst_seq #(.W(W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .stop_i   (stop_i),
        .col_i    (col_i),
        .cfg_i    (cmd_cfg),
        .active_o (active),
        .last_o   (last_beat),
        .base_o   (base),
        .beat_o   (beat),
        .cfg_o    (run_cfg)
    );

    brst_col_map #(.W(W)) u_map (
        .base_i (base),
        .beat_i (beat),
        .cfg_i  (run_cfg),
        .col_o  (mapped)
    );

    assign page_q  = run_cfg.page;
    assign col_o   = active ? mapped : '0;
    assign valid_o = active;
    assign last_o  = last_beat;
endmodule

// File: rtl/brst_col_gen_chk.sv
module brst_col_gen_chk #(
    parameter int W = 9
) (
    input logic         clk,
    input logic         rst,
    input logic         start_i,
    input logic         stop_i,
    input logic [W-1:0] col_i,
    input logic [W-1:0] col_o,
    input logic         valid_o,
    input logic         last_o,
    input logic         page_q
);
    a_r2_first_beat: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (valid_o && col_o == $past(col_i)));

    a_r4_block_fixed: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && !$past(start_i) && !page_q)
        |-> $stable(col_o[W-1:3]));

    a_r5_low_bit_moves: assert property (@(posedge clk) disable iff (rst)
        (valid_o && $past(valid_o) && !$past(start_i))
        |-> (col_o[0] != $past(col_o[0])));

    a_r7_page_no_last: assert property (@(posedge clk) disable iff (rst)
        (valid_o && page_q) |-> !last_o);

    a_r8_last_ends: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    a_r8_last_is_valid: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    a_r9_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (stop_i && valid_o && !start_i) |=> !valid_o);

    a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> (col_o == '0 && !last_o));
endmodule

bind brst_col_gen brst_col_gen_chk #(.W(W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .stop_i  (stop_i),
    .col_i   (col_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .last_o  (last_o),
    .page_q  (page_q)
);

// File: tb/brst_col_gen_tb_top.sv
module brst_col_gen_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       i_start = 1'b0;
    logic       i_wr = 1'b0;
    logic [8:0] i_col = '0;
    logic [2:0] i_len = '0;
    logic       i_ilv = 1'b0;
    logic       i_single = 1'b0;
    logic       i_stop = 1'b0;
    logic [8:0] col_o;
    logic       valid_o;
    logic       last_o;

    int    n_checks = 0;
    int    n_fail   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // Reference model state
    bit m_act = 1'b0;
    int m_base, m_beat, m_len, m_ilv;

    always #10 clk = ~clk;

    brst_col_gen dut_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (i_start),
        .is_wr_i     (i_wr),
        .col_i       (i_col),
        .len_sel_i   (i_len),
        .ilv_i       (i_ilv),
        .wr_single_i (i_single),
        .stop_i      (i_stop),
        .col_o       (col_o),
        .valid_o     (valid_o),
        .last_o      (last_o)
    );

    function automatic int len_of(input int sel);
        case (sel)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            4: return 0;
            default: return 1;
        endcase
    endfunction

    function automatic int exp_col();
        int blk, off;
        if (m_len == 0) return (m_base + m_beat) % 512;
        blk = (m_base / m_len) * m_len;
        off = m_base % m_len;
        if (m_ilv != 0) return blk + (off ^ m_beat);
        return blk + ((off + m_beat) % m_len);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_act = 1'b0;
        end else if (i_start) begin
            m_act  = 1'b1;
            m_base = int'(i_col);
            m_beat = 0;
            m_len  = (i_wr && i_single) ? 1 : len_of(int'(i_len));
            m_ilv  = (i_ilv && m_len != 0) ? 1 : 0;
        end else if (m_act) begin
            if (i_stop || (m_len != 0 && m_beat == m_len - 1)) m_act = 1'b0;
            else m_beat = (m_beat + 1) % 512;
        end
    end

    task automatic check(input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t",
                     cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check("valid", int'(valid_o), int'(m_act));
            if (m_act) begin
                check("col", int'(col_o), exp_col());
                check("last", int'(last_o),
                      (m_len != 0 && m_beat == m_len - 1) ? 1 : 0);
            end else begin
                check("idle col", int'(col_o), 0);
                check("idle last", int'(last_o), 0);
            end
        end
    end

    task automatic drive(input bit st, input bit sp, input int col, input int len,
                         input bit ilv, input bit wr, input bit sg);
        @(negedge clk);
        i_start  = st;
        i_stop   = sp;
        i_col    = 9'(col);
        i_len    = 3'(len);
        i_ilv    = ilv;
        i_wr     = wr;
        i_single = sg;
        @(negedge clk);
        i_start = 1'b0;
        i_stop  = 1'b0;
    endtask

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";
        gap(3);

        cur_req = "R3";   drive(1, 0, 9'h0A3, 1, 0, 0, 0); gap(4);
        cur_req = "R5";   drive(1, 0, 9'h1A1, 2, 0, 0, 0); gap(6);
        cur_req = "R6";   drive(1, 0, 9'h0AD, 3, 1, 0, 0); gap(10);
        cur_req = "R4";   drive(1, 0, 9'h136, 3, 0, 0, 0); gap(10);
        cur_req = "R6";   drive(1, 0, 9'h0FF, 2, 1, 0, 0); gap(6);
        cur_req = "R2";   drive(1, 0, 9'h077, 0, 0, 0, 0); gap(3);
        cur_req = "R3";   drive(1, 0, 9'h055, 6, 1, 0, 0); gap(3);
        cur_req = "R3";   drive(1, 0, 9'h056, 5, 0, 1, 0); gap(3);

        cur_req = "R7";   drive(1, 0, 9'd508, 4, 1, 0, 0); gap(12);
        cur_req = "R9";   drive(0, 1, 0, 0, 0, 0, 0); gap(4);
        cur_req = "R7";   drive(1, 0, 9'd3, 4, 0, 1, 0); gap(600);
        cur_req = "R9";   drive(0, 1, 0, 0, 0, 0, 0); gap(3);

        cur_req = "R9";   drive(1, 0, 9'h120, 3, 0, 0, 0); gap(2);
        drive(0, 1, 0, 0, 0, 0, 0); gap(3);
        drive(0, 1, 0, 0, 0, 0, 0); gap(3);

        cur_req = "R10";  drive(1, 0, 9'h043, 3, 0, 1, 1); gap(4);
        cur_req = "R10";  drive(1, 0, 9'h043, 4, 0, 1, 1); gap(4);
        cur_req = "R10";  drive(1, 0, 9'h043, 3, 1, 0, 1); gap(10);
        cur_req = "R10";  drive(1, 0, 9'h043, 2, 0, 1, 0); gap(6);

        cur_req = "R11";  drive(1, 0, 9'h1F2, 3, 0, 0, 0); gap(1);
        drive(1, 0, 9'h0C9, 2, 1, 0, 0);
        drive(1, 0, 9'h011, 3, 0, 0, 0); gap(10);
        cur_req = "R11";  drive(1, 0, 9'h100, 4, 0, 0, 0); gap(2);
        drive(1, 1, 9'h0E5, 2, 0, 0, 0); gap(6);
        cur_req = "R8";   drive(1, 0, 9'h0A0, 1, 0, 0, 0);
        drive(1, 0, 9'h0B3, 1, 1, 0, 0); gap(4);

        cur_req = "R1";
        @(negedge clk); rst = 1'b1;
        drive(1, 0, 9'h0AA, 3, 0, 0, 0);
        @(negedge clk); rst = 1'b0;
        gap(3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule